// File: doc/BRIEF.md
# Banked Interrupt Aggregator

This block collects 24 interrupt request lines into three byte-wide banks. It combines them into one summary line toward a host, which detects that line on its rising edge. Each input is resynchronised. On each rising edge, an edge-type input sets a status bit, but only while its mask bit enables it. The bit stays set until software reads the status register of that bank. That read returns the bits and clears them in the same access, so no separate acknowledge write exists.

One source, chosen by a parameter (source 12 by default, which is bank 1 bit 4), is level-sensitive. Its status bit follows the synchronised input, and a read does not clear it. The summary line is high while any source is both set in status and enabled in mask. It drops as soon as that pending set empties, so the next request produces a fresh rising edge at the host.

Software enables a source by a read-modify-write of a mask register that ORs the bit in, and disables it by ANDing the bit out. Every source is disabled after reset.

Top module: `irq_agg`

## Requirements
- R1: Source n maps to bank n/8, bit n%8. Bank b has its status register at offset 2b and its mask register at offset 2b+1, with offsets 0 to 5 in use. A request on one bank's source shows only in that bank's status.
- R2: While reset is low and after its release, all mask registers read 0x00, edge status bits read 0 and irq_o is 0.
- R3: The level source (default source 12, bank 1 bit 4) has a status bit equal to its synchronised input. A status read does not clear it, and the mask does not affect it. It counts as pending only while its mask bit is 1.
- R4: An edge source's status bit sets when a rising edge is captured while its mask bit is 1. A read of its bank's status register returns the bits as they were before the read and clears the edge bits at that clock edge.
- R5: A rising edge on an edge source whose mask bit is 0 is not latched. Setting the mask bit later does not make it pending.
- R6: If a status read and a newly captured edge in the same bank fall on the same clock edge, the new bit stays set after the read.
- R7: A write to a mask offset loads all 8 bits, and a read of that offset returns them. Writes to status offsets have no effect. Offsets 6 and 7 read 0x00.
- R8: irq_o is a registered OR of all pending bits, where a pending bit is status AND mask. It rises on the fourth clock edge after an unmasked edge-input rise and falls on the edge after the pending set empties, for example after a clearing read or a mask write.
- R9: Once irq_o has fallen, a later captured request drives it low-to-high again.
- R10: An input held high, or a falling input, does not set its edge status bit again after a read has cleared it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 24 | Asynchronous interrupt request inputs |
| addr_i | input | 3 | Register offset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears the status that is read) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of rd_en_i |
| irq_o | output | 1 | Summary interrupt, high while any source is pending |

## Verification
Lost or stale status is visible at two points. One is the byte returned by the next status read. The other is irq_o, which changes one clock edge after the pending set changes. A capture that was wrongly dropped shows as a zero read four edges after the input rose. A clear that was wrongly skipped shows as the same bit returned by two reads in a row. The summary line is sampled against the read and mask-write edges, so if it rises late or never falls, the mismatch appears within one cycle. The case where a read and an edge coincide is timed so that the edge is captured on exactly the same clock edge as the clearing read.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DEF_BANK_W    = 8;
  localparam int DEF_NUM_BANKS = 3;
  localparam int DEF_LEVEL_SRC = 12;
  localparam int DEF_SYNC_STG  = 2;

  // low address bit selects register kind inside a bank
  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_MASK   = 1'b1
  } reg_kind_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 24,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [STAGES-1:0][WIDTH-1:0] sh_q;
  logic [WIDTH-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= '0;
    end else begin
      sh_q[0] <= req_i;
      for (int s = 1; s < STAGES; s++) sh_q[s] <= sh_q[s-1];
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign sync_o = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int BANK_W    = 8,
  parameter bit LEVEL_EN  = 1'b0,
  parameter int LEVEL_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] sync_i,
  input  logic [BANK_W-1:0] rise_i,
  input  logic              mask_we_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic              rd_clr_i,
  output logic [BANK_W-1:0] stat_o,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] pend_o
);
  localparam logic [BANK_W-1:0] ONE_M  = {{(BANK_W-1){1'b0}}, 1'b1};
  localparam logic [BANK_W-1:0] LVL_M  = LEVEL_EN ? (ONE_M << LEVEL_BIT) : '0;
  localparam logic [BANK_W-1:0] EDGE_M = ~LVL_M;

  logic [BANK_W-1:0] stat_q, stat_d, mask_q, capt, keep;

  assign capt   = rise_i & mask_q;
  assign keep   = rd_clr_i ? '0 : stat_q;
  // edge bits: captured edge beats a concurrent clear; level bit tracks input
  assign stat_d = ((keep | capt) & EDGE_M) | (sync_i & LVL_M);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = stat_q & mask_q;

  a_r4_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && ((rise_i & mask_q) == '0)) |=> ((stat_q & EDGE_M) == '0));

  a_r6_new_edge_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && ((rise_i & mask_q & EDGE_M) != '0))
      |=> ((stat_q & $past(rise_i & mask_q & EDGE_M)) == $past(rise_i & mask_q & EDGE_M)));

  a_r5_set_needs_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~$past(stat_q) & EDGE_M & ~$past(rise_i & mask_q)) == '0));

  if (LEVEL_EN) begin : g_lvl_chk
    a_r3_level_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_q[LEVEL_BIT] == $past(sync_i[LEVEL_BIT]));
  end
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 8,
  parameter int ADDR_W    = 3
) (
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic                              wr_en_i,
  input  logic                              rd_en_i,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]  stat_i,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]  mask_i,
  output logic [NUM_BANKS-1:0]              mask_we_o,
  output logic [NUM_BANKS-1:0]              rd_clr_o,
  output logic [BANK_W-1:0]                 rdata_o
);
  logic [ADDR_W-2:0]    bank_idx;
  reg_kind_e            kind;
  logic [NUM_BANKS-1:0] hit;

  assign bank_idx = addr_i[ADDR_W-1:1];
  assign kind     = reg_kind_e'(addr_i[0]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    assign hit[b]       = (bank_idx == (ADDR_W-1)'(b));
    assign mask_we_o[b] = wr_en_i & hit[b] & (kind == REG_MASK);
    assign rd_clr_o[b]  = rd_en_i & hit[b] & (kind == REG_STATUS);
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit[b]) rdata_o = (kind == REG_MASK) ? mask_i[b] : stat_i[b];
    end
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS = DEF_NUM_BANKS,
  parameter int BANK_W    = DEF_BANK_W,
  parameter int LEVEL_SRC = DEF_LEVEL_SRC,
  parameter int SYNC_STG  = DEF_SYNC_STG,
  localparam int NUM_SRC  = NUM_BANKS * BANK_W,
  localparam int ADDR_W   = $clog2(2 * NUM_BANKS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [BANK_W-1:0]  wdata_i,
  output logic [BANK_W-1:0]  rdata_o,
  output logic               irq_o
);
  localparam logic [ADDR_W:0] NUM_REGS = (ADDR_W+1)'(2 * NUM_BANKS);

  logic [NUM_SRC-1:0]                sync, rise;
  logic [NUM_BANKS-1:0][BANK_W-1:0]  stat, mask, pend;
  logic [NUM_BANKS-1:0]              mask_we, rd_clr;
  logic                              irq_q;

  irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .req_i, .sync_o(sync), .rise_o(rise)
  );

  irq_regif #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_regif (
    .addr_i, .wr_en_i, .rd_en_i,
    .stat_i(stat), .mask_i(mask),
    .mask_we_o(mask_we), .rd_clr_o(rd_clr), .rdata_o
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_bank #(
      .BANK_W   (BANK_W),
      .LEVEL_EN ((LEVEL_SRC / BANK_W) == b),
      .LEVEL_BIT(LEVEL_SRC % BANK_W)
    ) u_bank (
      .clk_i, .rst_ni,
      .sync_i   (sync[b*BANK_W +: BANK_W]),
      .rise_i   (rise[b*BANK_W +: BANK_W]),
      .mask_we_i(mask_we[b]),
      .wdata_i,
      .rd_clr_i (rd_clr[b]),
      .stat_o   (stat[b]),
      .mask_o   (mask[b]),
      .pend_o   (pend[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend;
  end

  assign irq_o = irq_q;

  a_r7_unused_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, addr_i} >= NUM_REGS) |-> (rdata_o == '0));

  a_r7_status_write_no_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i[0]) |=> $stable(mask));
endmodule

// File: tb/irq_agg_tb.sv
module irq_agg_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] req = '0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] exp;
    logic [2:0] a;
    string      tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #5 clk = ~clk;

  irq_agg u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: compare read data against the scoreboard mid-cycle
  always @(negedge clk) begin
    if (rd_en && sb_q.size() > 0) begin
      rd_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        errors++;
        $display("FAIL %s read offset %0d: got %02h expected %02h", it.tag, it.a, rdata, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    it.exp = e; it.a = a; it.tag = tag;
    sb_q.push_back(it);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq_o: got %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    idle(3);
    chk_irq(1'b0, "R2");
    rst_ni = 1'b1;
    idle(1);
    // R2 reset state
    chk_irq(1'b0, "R2");
    rd(1, 8'h00, "R2"); rd(3, 8'h00, "R2"); rd(5, 8'h00, "R2");
    rd(0, 8'h00, "R2"); rd(4, 8'h00, "R2");

    // R7 mask register access, status writes ignored, unused offsets
    wr(1, 8'hA5); rd(1, 8'hA5, "R7");
    wr(3, 8'h3C); rd(3, 8'h3C, "R7");
    wr(5, 8'h81); rd(5, 8'h81, "R7");
    wr(0, 8'hFF); rd(0, 8'h00, "R7"); rd(1, 8'hA5, "R7");
    wr(2, 8'hFF); rd(2, 8'h00, "R7");
    rd(6, 8'h00, "R7"); rd(7, 8'h00, "R7");
    wr(1, 8'hFF); wr(3, 8'hFF); wr(5, 8'hFF);

    // R1 bank mapping, R4 capture and read-clear, R8 irq timing
    req = (24'd1 << 3) | (24'd1 << 9) | (24'd1 << 21);
    idle(3);
    chk_irq(1'b0, "R8");
    idle(1);
    chk_irq(1'b1, "R8");
    rd(0, 8'h08, "R1"); rd(2, 8'h02, "R1"); rd(4, 8'h20, "R1");
    chk_irq(1'b1, "R8");
    idle(1);
    chk_irq(1'b0, "R8");
    rd(0, 8'h00, "R4"); rd(2, 8'h00, "R4"); rd(4, 8'h00, "R10");

    // R5 edge while masked is lost
    req = '0; idle(3);
    wr(1, 8'hF7);
    req[3] = 1'b1; idle(4);
    chk_irq(1'b0, "R5");
    rd(0, 8'h00, "R5");
    req = '0; idle(3);
    wr(1, 8'hFF); idle(1);
    chk_irq(1'b0, "R5");
    rd(0, 8'h00, "R5");

    // R3 level source bank 1 bit 4
    req[12] = 1'b1; idle(4);
    chk_irq(1'b1, "R3");
    rd(2, 8'h10, "R3"); rd(2, 8'h10, "R3");
    chk_irq(1'b1, "R3");
    wr(3, 8'hEF); idle(1);
    chk_irq(1'b0, "R3");
    rd(2, 8'h10, "R3");
    req[12] = 1'b0; idle(3);
    rd(2, 8'h00, "R3");
    wr(3, 8'hFF); idle(1);
    chk_irq(1'b0, "R3");

    // R6 read coinciding with a new edge
    req = 24'h000002; idle(4);
    req = 24'h000003; idle(2);
    rd(0, 8'h02, "R6");
    rd(0, 8'h01, "R6");
    idle(1);
    chk_irq(1'b0, "R6");

    // R9 fresh rising edge after fall
    req = '0; idle(3);
    req = 24'h000001; idle(3);
    chk_irq(1'b0, "R9");
    idle(1);
    chk_irq(1'b1, "R9");
    rd(0, 8'h01, "R9");
    idle(1);
    chk_irq(1'b0, "R9");

    // R10 held high and falling inputs do not re-capture
    idle(4);
    rd(0, 8'h00, "R10");
    req = '0; idle(4);
    rd(0, 8'h00, "R10");
    chk_irq(1'b0, "R10");

    // R8 mask write drops and restores the summary
    req = 24'h000004; idle(4);
    chk_irq(1'b1, "R8");
    wr(1, 8'hFB); idle(1);
    chk_irq(1'b0, "R8");
    wr(1, 8'hFF); idle(1);
    chk_irq(1'b1, "R8");
    rd(0, 8'h04, "R8");
    idle(1);
    chk_irq(1'b0, "R8");

    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule